// File: doc/BRIEF.md
# SPI FIFO and Interrupt Status Unit

This block sits between a processor register port and the serial engine of an SPI controller. It holds one transmit queue and one receive queue of 16 entries each. The processor fills the transmit queue by writing a data window and drains the receive queue by reading another window. The serial engine takes transmit entries and delivers received entries over two valid/ready streams. A configuration word sets the entry width (1 to 4 bytes), the receive and transmit thresholds, and one flush strobe per queue. A status word reports the live occupancy of both queues.

Each direction has three registers: a flag register, an enable register and a clear register. Each direction drives its own interrupt line. Level flags (transmit full, transmit empty, receive above threshold) always follow the current queue state. A pulse on the released input sets a sticky event flag in both directions, and that flag stays set until software clears it.

Stream rules: `tx_valid` is high whenever the transmit queue holds an entry. One entry leaves on each cycle where `tx_valid` and `tx_ready` are both high. While `tx_ready` stays low, `tx_data` holds its value. `rx_ready` is high whenever the receive queue has room. The engine must hold `rx_valid` and `rx_data` until it sees `rx_ready`. A beat is taken only on a cycle where both are high.

Register map, by offset:

| Offset | Register | Access |
|---|---|---|
| 0x14 | TX flags | read |
| 0x18 | TX enables | read/write |
| 0x1C | TX clear | write |
| 0x20 | RX flags | read |
| 0x24 | RX enables | read/write |
| 0x28 | RX clear | write |
| 0x40 | occupancy status | read |
| 0x4C | configuration | read/write |
| 0x50 | TX data window | write |
| 0x90 | RX data window | read |

Top module: `spi_fifo_irq`

## Requirements
- R1: After reset both queues are empty. The status word (0x40) reads 0, the TX flags (0x14) read 0x02, the RX flags (0x20) read 0, both interrupt lines are low, `tx_valid` is low and `rx_ready` is high.
- R2: Words written to the TX window (0x50) leave on the transmit stream in write order. `tx_valid` and `tx_data` hold steady while `tx_ready` is low.
- R3: A write to the TX window while the transmit queue holds 16 entries is dropped. In that state TX flag bit 0 (full) is set.
- R4: Reads of the RX window (0x90) return received entries in arrival order and pop one entry each. A read of an empty receive queue returns 0 and changes nothing. `rx_ready` is low only while the receive queue holds 16 entries.
- R5: The status word at 0x40 carries the receive occupancy in bits 12:8 and the transmit occupancy in bits 20:16.
- R6: Configuration (0x4C) bits 9:8 set the entry width as bytes minus one. Every entry is masked to that many low bytes at the moment it enters either queue.
- R7: RX flag bit 5 is 1 exactly when the receive occupancy is greater than the RX threshold in configuration bits 3:0. TX flag bit 1 is 1 exactly when the transmit queue is empty. Configuration bits 7:4 hold the TX threshold as stored, read-back state.
- R8: Writing configuration bit 11 empties the receive queue in one cycle. Writing bit 12 empties the transmit queue in one cycle. Both bits read back as 0, and the same write stores the other fields.
- R9: A pulse on `released` sets bit 6 in both flag registers, and the bit stays set. Writing a 1 to a bit of a clear register (0x1C TX, 0x28 RX) clears that sticky bit. An event in the same cycle as a clear leaves the bit set.
- R10: `irq_tx` is high when any TX flag bit ANDed with the matching bit of the TX enables (0x18) is 1. `irq_rx` is formed the same way from the RX flags and RX enables (0x24). The two lines are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 8 | Write byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Register read strobe (pops on the RX window) |
| reg_raddr | input | 8 | Read byte offset |
| reg_rdata | output | 32 | Read data, combinational from `reg_raddr` |
| tx_valid | output | 1 | Transmit entry available |
| tx_ready | input | 1 | Engine takes the transmit entry |
| tx_data | output | 32 | Head transmit entry |
| rx_valid | input | 1 | Engine offers a received entry |
| rx_ready | output | 1 | Receive queue has room |
| rx_data | input | 32 | Received entry |
| released | input | 1 | Peripheral-released event pulse |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |

## Verification
A table of width code, raw word and masked word is sent through both queues. This shows that masking applies on both entry paths and separates each of the four width codes. The transmit queue is filled past 16 entries and then drained. This separates a correctly dropped extra write from wrap-around corruption, and a held stream under back-pressure from a premature pop. Receive occupancy is stepped across a threshold of 2, so that the greater-than comparison is told apart from greater-or-equal. Release events are combined with one-sided clears and with a clear in the same cycle. This tells sticky, per-direction and set-priority behaviour apart, and enable patterns then show that each interrupt line follows only its own direction.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int DATA_W = 32;
  localparam int BYTE_W = 8;
  localparam int NBYTES = DATA_W / BYTE_W;
  localparam int ADDR_W = 8;
  localparam int FLAG_W = 8;

  localparam logic [ADDR_W-1:0] A_TX_FLAG = 8'h14;
  localparam logic [ADDR_W-1:0] A_TX_EN   = 8'h18;
  localparam logic [ADDR_W-1:0] A_TX_CLR  = 8'h1C;
  localparam logic [ADDR_W-1:0] A_RX_FLAG = 8'h20;
  localparam logic [ADDR_W-1:0] A_RX_EN   = 8'h24;
  localparam logic [ADDR_W-1:0] A_RX_CLR  = 8'h28;
  localparam logic [ADDR_W-1:0] A_STATUS  = 8'h40;
  localparam logic [ADDR_W-1:0] A_CFG     = 8'h4C;
  localparam logic [ADDR_W-1:0] A_TX_WIN  = 8'h50;
  localparam logic [ADDR_W-1:0] A_RX_WIN  = 8'h90;

  localparam int B_TX_FULL  = 0;
  localparam int B_TX_EMPTY = 1;
  localparam int B_RX_ABOVE = 5;
  localparam int B_RELEASED = 6;

  localparam int CFG_RX_FLUSH = 11;
  localparam int CFG_TX_FLUSH = 12;
  localparam int ST_RX_LSB = 8;
  localparam int ST_TX_LSB = 16;

  localparam logic [FLAG_W-1:0] TX_LEVEL_MASK = FLAG_W'((1 << B_TX_FULL) | (1 << B_TX_EMPTY));
  localparam logic [FLAG_W-1:0] RX_LEVEL_MASK = FLAG_W'(1 << B_RX_ABOVE);
  localparam logic [FLAG_W-1:0] EVT_MASK      = FLAG_W'(1 << B_RELEASED);

  function automatic logic [DATA_W-1:0] mask_entry(input logic [DATA_W-1:0] d,
                                                   input logic [1:0] code);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int b = 0; b < NBYTES; b++) begin
      if (b <= int'(code)) r[b*BYTE_W +: BYTE_W] = d[b*BYTE_W +: BYTE_W];
    end
    return r;
  endfunction
endpackage

// File: rtl/spi_fifo_queue.sv
module spi_fifo_queue #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [$clog2(DEPTH):0] count,
  output logic             full,
  output logic             empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = mem[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == PW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == PW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (count == CW'(DEPTH)));
  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit
  import spi_fifo_pkg::*;
#(
  parameter logic [FLAG_W-1:0] LEVEL_MASK = '0,
  parameter logic [FLAG_W-1:0] STICKY_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] level,
  input  logic              event_in,
  input  logic              wr_en_reg,
  input  logic              wr_clr,
  input  logic [FLAG_W-1:0] wdata,
  output logic [FLAG_W-1:0] flags,
  output logic [FLAG_W-1:0] enables,
  output logic              irq
);
  logic [FLAG_W-1:0] sticky;
  logic [FLAG_W-1:0] clr_mask;

  assign clr_mask = wr_clr ? wdata : '0;
  assign flags    = (level & LEVEL_MASK) | sticky;
  assign irq      = |(flags & enables);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky  <= '0;
      enables <= '0;
    end else begin
      sticky <= ((sticky & ~clr_mask) | (event_in ? STICKY_MASK : '0)) & STICKY_MASK;
      if (wr_en_reg) enables <= wdata & (LEVEL_MASK | STICKY_MASK);
    end
  end

  assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_clr |=> ((sticky & $past(sticky)) == $past(sticky)));
  assert_event_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    event_in |=> ((flags & STICKY_MASK) == STICKY_MASK));
endmodule

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_waddr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_raddr,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              released,
  output logic              irq_tx,
  output logic              irq_rx
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [3:0] rx_thr, tx_thr;
  logic [1:0] wcode;
  logic       wr_cfg, tx_flush, rx_flush;
  logic [CW-1:0] tx_count, rx_count;
  logic       tx_full, tx_empty, rx_full, rx_empty;
  logic [DATA_W-1:0] rx_head;
  logic       rx_above;
  logic [FLAG_W-1:0] tx_level, rx_level;
  logic [FLAG_W-1:0] tx_flags, rx_flags, tx_en, rx_en;
  logic       rx_pop;

  assign wr_cfg   = reg_wr && (reg_waddr == A_CFG);
  assign tx_flush = wr_cfg && reg_wdata[CFG_TX_FLUSH];
  assign rx_flush = wr_cfg && reg_wdata[CFG_RX_FLUSH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_thr <= '0;
      tx_thr <= '0;
      wcode  <= '0;
    end else if (wr_cfg) begin
      rx_thr <= reg_wdata[3:0];
      tx_thr <= reg_wdata[7:4];
      wcode  <= reg_wdata[9:8];
    end
  end

  spi_fifo_queue #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(reg_wr && (reg_waddr == A_TX_WIN)),
    .push_data(mask_entry(reg_wdata, wcode)),
    .pop(tx_valid && tx_ready),
    .head(tx_data), .count(tx_count), .full(tx_full), .empty(tx_empty));

  assign rx_pop = reg_rd && (reg_raddr == A_RX_WIN);

  spi_fifo_queue #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(rx_valid && rx_ready),
    .push_data(mask_entry(rx_data, wcode)),
    .pop(rx_pop),
    .head(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty));

  assign tx_valid = !tx_empty;
  assign rx_ready = !rx_full;
  assign rx_above = int'(rx_count) > int'(rx_thr);

  always_comb begin
    tx_level = '0;
    tx_level[B_TX_FULL]  = tx_full;
    tx_level[B_TX_EMPTY] = tx_empty;
    rx_level = '0;
    rx_level[B_RX_ABOVE] = rx_above;
  end

  spi_flag_unit #(.LEVEL_MASK(TX_LEVEL_MASK), .STICKY_MASK(EVT_MASK)) u_txflag (
    .clk(clk), .rst_n(rst_n), .level(tx_level), .event_in(released),
    .wr_en_reg(reg_wr && (reg_waddr == A_TX_EN)),
    .wr_clr(reg_wr && (reg_waddr == A_TX_CLR)),
    .wdata(reg_wdata[FLAG_W-1:0]),
    .flags(tx_flags), .enables(tx_en), .irq(irq_tx));

  spi_flag_unit #(.LEVEL_MASK(RX_LEVEL_MASK), .STICKY_MASK(EVT_MASK)) u_rxflag (
    .clk(clk), .rst_n(rst_n), .level(rx_level), .event_in(released),
    .wr_en_reg(reg_wr && (reg_waddr == A_RX_EN)),
    .wr_clr(reg_wr && (reg_waddr == A_RX_CLR)),
    .wdata(reg_wdata[FLAG_W-1:0]),
    .flags(rx_flags), .enables(rx_en), .irq(irq_rx));

  always_comb begin
    reg_rdata = '0;
    case (reg_raddr)
      A_TX_FLAG: reg_rdata = DATA_W'(tx_flags);
      A_TX_EN:   reg_rdata = DATA_W'(tx_en);
      A_RX_FLAG: reg_rdata = DATA_W'(rx_flags);
      A_RX_EN:   reg_rdata = DATA_W'(rx_en);
      A_STATUS:  reg_rdata = (DATA_W'(rx_count) << ST_RX_LSB) | (DATA_W'(tx_count) << ST_TX_LSB);
      A_CFG:     reg_rdata = DATA_W'({wcode, tx_thr, rx_thr});
      A_RX_WIN:  reg_rdata = rx_empty ? '0 : rx_head;
      default:   reg_rdata = '0;
    endcase
  end

  assert_empty_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && rx_empty) |-> (reg_rdata == '0));
  assert_tx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !tx_flush) |=> (tx_valid && $stable(tx_data)));
  assert_rx_backpressure_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == CW'(DEPTH)) |-> !rx_ready);
endmodule

// File: tb/spi_fifo_irq_bench.sv
`timescale 1ns/1ps
module spi_fifo_irq_bench;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_waddr = 0, reg_raddr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic tx_valid, tx_ready = 0, rx_valid = 0, rx_ready, released = 0, irq_tx, irq_rx;
  logic [31:0] tx_data, rx_data = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spi_fifo_irq u_spi_fifo_irq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .released(released), .irq_tx(irq_tx), .irq_rx(irq_rx));

  // {width code, raw word, masked word}
  localparam logic [65:0] VEC [5] = '{
    {2'd3, 32'hDEADBEEF, 32'hDEADBEEF},
    {2'd0, 32'hDEADBEEF, 32'h000000EF},
    {2'd1, 32'h12345678, 32'h00005678},
    {2'd2, 32'h12345678, 32'h00345678},
    {2'd0, 32'hA5A5A5FF, 32'h000000FF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_waddr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_raddr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic rx_push(input logic [31:0] d);
    @(negedge clk); rx_valid = 1; rx_data = d;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic tx_take(input string req, input logic [31:0] exp);
    @(negedge clk);
    chk(req, {31'd0, tx_valid}, 32'd1);
    chk(req, tx_data, exp);
    tx_ready = 1;
    @(negedge clk); tx_ready = 0;
  endtask

  task automatic pulse_release;
    @(negedge clk); released = 1;
    @(negedge clk); released = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(8'h40, v); chk("R1 status", v, 32'h0);
    rd(8'h14, v); chk("R1 txflags", v, 32'h02);
    rd(8'h20, v); chk("R1 rxflags", v, 32'h00);
    chk("R1 irq", {30'd0, irq_tx, irq_rx}, 32'd0);
    chk("R1 tx_valid", {31'd0, tx_valid}, 32'd0);
    chk("R1 rx_ready", {31'd0, rx_ready}, 32'd1);

    // R6 width table on both paths
    for (int i = 0; i < 5; i++) begin
      wr(8'h4C, {22'd0, VEC[i][65:64], 8'd0});
      wr(8'h50, VEC[i][63:32]);
      tx_take("R6 tx width", VEC[i][31:0]);
      rx_push(VEC[i][63:32]);
      rd(8'h90, v); chk("R6 rx width", v, VEC[i][31:0]);
    end

    // R2 ordering and back-pressure
    wr(8'h4C, 32'h300);
    wr(8'h50, 32'h11); wr(8'h50, 32'h22); wr(8'h50, 32'h33);
    repeat (4) @(negedge clk);
    chk("R2 hold valid", {31'd0, tx_valid}, 32'd1);
    chk("R2 hold data", tx_data, 32'h11);
    tx_take("R2 order", 32'h11); tx_take("R2 order", 32'h22); tx_take("R2 order", 32'h33);
    @(negedge clk); chk("R2 drained", {31'd0, tx_valid}, 32'd0);

    // R3 full drop, R5 tx count field
    for (int i = 0; i < 17; i++) wr(8'h50, 32'h100 + i);
    rd(8'h40, v); chk("R5 tx count", v, 32'h0010_0000);
    rd(8'h14, v); chk("R3 full flag", v, 32'h01);
    for (int i = 0; i < 16; i++) tx_take("R3 drain", 32'h100 + i);
    @(negedge clk); chk("R3 dropped", {31'd0, tx_valid}, 32'd0);

    // R7 threshold, R5 rx count
    wr(8'h4C, 32'h302);
    rx_push(32'hA1); rx_push(32'hA2);
    rd(8'h20, v); chk("R7 at thr", v, 32'h00);
    rx_push(32'hA3);
    rd(8'h20, v); chk("R7 above thr", v, 32'h20);
    rd(8'h40, v); chk("R5 rx count", v, 32'h0000_0300);
    // R4 order then empty read
    rd(8'h90, v); chk("R4 order", v, 32'hA1);
    rd(8'h90, v); chk("R4 order", v, 32'hA2);
    rd(8'h90, v); chk("R4 order", v, 32'hA3);
    rd(8'h90, v); chk("R4 empty read", v, 32'h0);
    rd(8'h40, v); chk("R4 empty count", v, 32'h0);

    // R4 rx full back-pressure, R8 rx flush
    for (int i = 0; i < 16; i++) rx_push(32'h200 + i);
    @(negedge clk); chk("R4 rx_ready full", {31'd0, rx_ready}, 32'd0);
    rd(8'h90, v); chk("R4 full head", v, 32'h200);
    wr(8'h4C, 32'hB02);
    rd(8'h40, v); chk("R8 rx flush", v, 32'h0);
    rd(8'h4C, v); chk("R8 cfg readback", v, 32'h302);
    // R8 tx flush
    wr(8'h50, 32'h5); wr(8'h50, 32'h6);
    wr(8'h4C, 32'h1302);
    rd(8'h40, v); chk("R8 tx flush", v, 32'h0);
    chk("R8 tx flush valid", {31'd0, tx_valid}, 32'd0);

    // R9 sticky release
    pulse_release;
    rd(8'h14, v); chk("R9 tx sticky", v, 32'h42);
    rd(8'h20, v); chk("R9 rx sticky", v, 32'h40);
    repeat (3) @(negedge clk);
    rd(8'h20, v); chk("R9 rx holds", v, 32'h40);
    wr(8'h1C, 32'h40);
    rd(8'h14, v); chk("R9 tx cleared", v, 32'h02);
    rd(8'h20, v); chk("R9 rx untouched", v, 32'h40);
    @(negedge clk); reg_wr = 1; reg_waddr = 8'h28; reg_wdata = 32'hFFFF_FFFF; released = 1;
    @(negedge clk); reg_wr = 0; released = 0;
    rd(8'h20, v); chk("R9 set wins", v, 32'h40);
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h20, v); chk("R9 rx cleared", v, 32'h00);

    // R10 interrupts
    @(negedge clk); chk("R10 idle", {30'd0, irq_tx, irq_rx}, 32'd0);
    pulse_release;
    wr(8'h24, 32'h40);
    @(negedge clk); chk("R10 rx only", {30'd0, irq_tx, irq_rx}, 32'd1);
    wr(8'h18, 32'h02);
    @(negedge clk); chk("R10 tx empty", {30'd0, irq_tx, irq_rx}, 32'd3);
    wr(8'h50, 32'h77);
    @(negedge clk); chk("R10 tx level drop", {30'd0, irq_tx, irq_rx}, 32'd1);
    rd(8'h18, v); chk("R10 tx enables", v, 32'h02);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule